// File: doc/BRIEF.md
# Fixed-Point Feature Broadcast Cache

This block holds one feature vector of 2048 signed 27-bit fixed-point elements between an upstream producer and a wide array of compute lanes. The producer fills it with wide words, sixteen elements per word. The block keeps its own word pointer, so the producer only raises a write strobe with each word.

When a read-start pulse arrives, the cache walks the vector from the first element to the last, one element per clock. It places each element on all 32 output lanes in the same cycle. The storage is modelled with a two-cycle read latency: one register for the word fetch and one for the element select. The valid flag goes through three registers, so it lines up with the data on the lanes.

Top module: `feat_bcast_cache`

## Requirements
- R1: After reset, `busy_o` and `valid_o` are low and every bit of `lanes_o` is zero.
- R2: In a write word, element k (k = 0..15) occupies bits [27k+26 : 27k], so element 0 is in bits [26:0]. When the word is written to word slot w, element k lands at element address w*16 + k.
- R3: The internal 7-bit word pointer starts at 0 after reset and advances by one on each cycle with `wr_en_i` high. It wraps from 127 to 0, so the 129th write overwrites slot 0.
- R4: Suppose `rd_start_i` is high at a clock edge while `busy_o` is low. Then `busy_o` is high from that edge for exactly 2048 cycles and then falls.
- R5: A read pass delivers element addresses 0, 1, …, 2047 in order, one per cycle, with no gaps.
- R6: Suppose the start is sampled at edge n. Then `valid_o` is high from edge n+2 for exactly 2048 cycles, and `lanes_o` carries element 0 in the first of those cycles.
- R7: While `valid_o` is high, all 32 lane fields of `lanes_o` carry the same element. Lane j is bits [27j+26 : 27j].
- R8: A `rd_start_i` pulse while `busy_o` is high is ignored. The running pass neither restarts nor lengthens.
- R9: A cycle with `wr_en_i` low neither changes the stored data nor advances the word pointer, whatever `wr_data_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one wide word |
| wr_data_i | input | 432 | Sixteen packed 27-bit elements |
| rd_start_i | input | 1 | Starts a full read pass when idle |
| busy_o | output | 1 | A read pass is issuing addresses |
| valid_o | output | 1 | `lanes_o` holds a read element |
| lanes_o | output | 864 | Thirty-two copies of the current element |

## Verification
The start edge n sets `busy_o` at once. `valid_o` and element 0 follow at edge n+2, after the word fetch and the element select. `busy_o` falls 2048 cycles after n, and `valid_o` falls two cycles later. The bench drives every input on the falling edge. After each start it samples the outputs on each falling edge and keeps an index of the rising edges since the start. At index c it expects `busy_o` for c below 2048 and `valid_o` for c from 2 to 2049, with element c-2 on every lane. A write is visible to any pass started on a later edge.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int unsigned ELEM_W_DFLT = 27;
  localparam int unsigned EPW_DFLT    = 16;
  localparam int unsigned DEPTH_DFLT  = 2048;
  localparam int unsigned LANES_DFLT  = 32;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fbc_wr_ctrl.sv
module fbc_wr_ctrl #(
  parameter int unsigned WORDS   = 128,
  parameter int unsigned WADDR_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  output logic [WADDR_W-1:0] wr_addr_o
);
  localparam logic [WADDR_W-1:0] LAST = WADDR_W'(WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_addr_o <= '0;
    else if (wr_en_i) wr_addr_o <= (wr_addr_o == LAST) ? '0 : wr_addr_o + 1'b1;
  end
endmodule

// File: rtl/fbc_rd_seq.sv
module fbc_rd_seq #(
  parameter int unsigned DEPTH   = 2048,
  parameter int unsigned RADDR_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               rd_en_o,
  output logic [RADDR_W-1:0] rd_addr_o
);
  localparam logic [RADDR_W-1:0] LAST = RADDR_W'(DEPTH - 1);

  // rd_en_o is the first stage of the valid chain and doubles as busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
    end else if (!rd_en_o) begin
      if (start_i) begin
        rd_en_o   <= 1'b1;
        rd_addr_o <= '0;
      end
    end else if (rd_addr_o == LAST) begin
      rd_en_o <= 1'b0;
    end else begin
      rd_addr_o <= rd_addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/fbc_store.sv
module fbc_store #(
  parameter int unsigned ELEM_W  = 27,
  parameter int unsigned EPW     = 16,
  parameter int unsigned WORDS   = 128,
  parameter int unsigned WADDR_W = 7,
  parameter int unsigned RADDR_W = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [WADDR_W-1:0]    wr_addr_i,
  input  logic [EPW*ELEM_W-1:0] wr_data_i,
  input  logic                  rd_en_i,
  input  logic [RADDR_W-1:0]    rd_addr_i,
  input  logic                  sel_en_i,
  output logic [ELEM_W-1:0]     rd_elem_o
);
  localparam int unsigned WORD_W = EPW * ELEM_W;
  localparam int unsigned SEL_W  = RADDR_W - WADDR_W;

  logic [WORD_W-1:0] mem_q [WORDS];
  logic [WORD_W-1:0] word_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ELEM_W-1:0] elem_pick;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // latency stage 1: word fetch
  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      word_q <= mem_q[rd_addr_i[RADDR_W-1:SEL_W]];
      sel_q  <= rd_addr_i[SEL_W-1:0];
    end
  end

  always_comb begin
    elem_pick = '0;
    for (int k = 0; k < int'(EPW); k++) begin
      if (sel_q == SEL_W'(k)) elem_pick = word_q[k*ELEM_W +: ELEM_W];
    end
  end

  // latency stage 2: element select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_elem_o <= '0;
    else if (sel_en_i) rd_elem_o <= elem_pick;
  end
endmodule

// File: rtl/fbc_bcast.sv
module fbc_bcast #(
  parameter int unsigned ELEM_W = 27,
  parameter int unsigned LANES  = 32
) (
  input  logic [ELEM_W-1:0]       elem_i,
  output logic [LANES*ELEM_W-1:0] lanes_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lanes_o[j*ELEM_W +: ELEM_W] = elem_i;
  end
endmodule

// File: rtl/feat_bcast_cache.sv
module feat_bcast_cache
  import fbc_pkg::*;
#(
  parameter int unsigned ELEM_W = ELEM_W_DFLT,
  parameter int unsigned EPW    = EPW_DFLT,
  parameter int unsigned DEPTH  = DEPTH_DFLT,
  parameter int unsigned LANES  = LANES_DFLT
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [EPW*ELEM_W-1:0]   wr_data_i,
  input  logic                    rd_start_i,
  output logic                    busy_o,
  output logic                    valid_o,
  output logic [LANES*ELEM_W-1:0] lanes_o
);
  localparam int unsigned WORDS   = DEPTH / EPW;
  localparam int unsigned WADDR_W = idx_w(WORDS);
  localparam int unsigned RADDR_W = idx_w(DEPTH);

  logic [WADDR_W-1:0] wr_addr;
  logic [RADDR_W-1:0] rd_addr;
  logic               rd_en;
  logic               vld_mid_q;
  logic               vld_out_q;
  logic [ELEM_W-1:0]  elem;

  fbc_wr_ctrl #(.WORDS(WORDS), .WADDR_W(WADDR_W)) u_wr (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_o(wr_addr)
  );

  fbc_rd_seq #(.DEPTH(DEPTH), .RADDR_W(RADDR_W)) u_seq (
    .clk_i, .rst_ni, .start_i(rd_start_i), .rd_en_o(rd_en), .rd_addr_o(rd_addr)
  );

  fbc_store #(
    .ELEM_W(ELEM_W), .EPW(EPW), .WORDS(WORDS), .WADDR_W(WADDR_W), .RADDR_W(RADDR_W)
  ) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i(wr_addr), .wr_data_i,
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .sel_en_i(vld_mid_q), .rd_elem_o(elem)
  );

  fbc_bcast #(.ELEM_W(ELEM_W), .LANES(LANES)) u_bcast (
    .elem_i(elem), .lanes_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_mid_q <= 1'b0;
      vld_out_q <= 1'b0;
    end else begin
      vld_mid_q <= rd_en;
      vld_out_q <= vld_mid_q;
    end
  end

  assign busy_o  = rd_en;
  assign valid_o = vld_out_q;
endmodule

// File: rtl/feat_bcast_cache_chk.sv
module feat_bcast_cache_chk #(
  parameter int unsigned ELEM_W  = 27,
  parameter int unsigned DEPTH   = 2048,
  parameter int unsigned LANES   = 32,
  parameter int unsigned WORDS   = 128,
  parameter int unsigned WADDR_W = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [WADDR_W-1:0]      wr_addr,
  input logic                    busy_o,
  input logic                    valid_o,
  input logic [LANES*ELEM_W-1:0] lanes_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;
  logic [CNT_W-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else             busy_cnt_q <= '0;
  end

  a_r3_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> wr_addr == (($past(wr_addr) == WADDR_W'(WORDS - 1)) ? '0 : $past(wr_addr) + 1'b1));

  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_addr));

  a_r4_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_cnt_q < CNT_W'(DEPTH));

  a_r4_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt_q == CNT_W'(DEPTH));

  a_r8_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && busy_cnt_q != CNT_W'(DEPTH - 1)) |=> busy_o);

  a_r6_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ##2 $rose(valid_o));

  a_r6_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ##2 $fell(valid_o));

  a_r7_lanes_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> lanes_o == {LANES{lanes_o[ELEM_W-1:0]}});
endmodule

bind feat_bcast_cache feat_bcast_cache_chk #(
  .ELEM_W(ELEM_W), .DEPTH(DEPTH), .LANES(LANES), .WORDS(WORDS), .WADDR_W(WADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr(wr_addr),
  .busy_o(busy_o), .valid_o(valid_o), .lanes_o(lanes_o)
);

// File: tb/feat_bcast_cache_test.sv
`timescale 1ns/1ps
module feat_bcast_cache_test;
  localparam int EW = 27, EPW = 16, DEPTH = 2048, LANES = 32, WORDS = DEPTH / EPW;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  wr_en_i = 1'b0;
  logic [EPW*EW-1:0]     wr_data_i = '0;
  logic                  rd_start_i = 1'b0;
  logic                  busy_o, valid_o;
  logic [LANES*EW-1:0]   lanes_o;

  int n_chk = 0, n_fail = 0, wptr = 0;
  bit done = 0;
  logic [EW-1:0] exp_mem [DEPTH];

  always #2.5 clk_i = ~clk_i;

  feat_bcast_cache uut (.*);

  function automatic logic [EW-1:0] gen(input int idx, input int seed);
    return EW'((idx * 32'h9E37 + seed) ^ (idx << 13));
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic put_word(input int seed);
    logic [EPW*EW-1:0] d;
    for (int k = 0; k < EPW; k++) begin
      d[k*EW +: EW] = gen(wptr * EPW + k, seed);
      exp_mem[wptr * EPW + k] = d[k*EW +: EW];
    end
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wptr = (wptr + 1) % WORDS;
  endtask

  // R9: idle cycles with garbage on the data bus
  task automatic idle_garbage(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      wr_en_i = 1'b0;
      wr_data_i = {EPW{27'h5A5A5A5 ^ 27'(i)}};
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    wptr = 0;
    @(negedge clk_i);
    check("R1 busy", busy_o == 1'b0, busy_o, 0);
    check("R1 valid", valid_o == 1'b0, valid_o, 0);
    check("R1 lanes", lanes_o == '0, lanes_o[EW-1:0], 0);
  endtask

  // start sampled at edge E0; sample index c = negedge after E(c)
  task automatic read_pass(input string tag, input bit repulse);
    int bad_busy = 0, bad_vld = 0, bad_dat = 0, bad_lane = 0;
    longint ab = 0, av = 0, ad = 0, ed = 0, al = 0;
    @(negedge clk_i);
    rd_start_i = 1'b1;
    for (int c = 0; c < DEPTH + 4; c++) begin
      @(negedge clk_i);
      rd_start_i = repulse && (c == 100 || c == 1500);
      if (busy_o !== (c < DEPTH)) begin if (bad_busy == 0) ab = c; bad_busy++; end
      if (valid_o !== (c >= 2 && c < DEPTH + 2)) begin if (bad_vld == 0) av = c; bad_vld++; end
      if (c >= 2 && c < DEPTH + 2) begin
        if (lanes_o[EW-1:0] !== exp_mem[c-2]) begin
          if (bad_dat == 0) begin ad = lanes_o[EW-1:0]; ed = exp_mem[c-2]; end
          bad_dat++;
        end
        if (lanes_o !== {LANES{exp_mem[c-2]}}) begin
          if (bad_lane == 0) al = lanes_o[(LANES-1)*EW +: EW];
          bad_lane++;
        end
      end
    end
    rd_start_i = 1'b0;
    check({tag, " R4 busy window (act=first bad cycle)"}, bad_busy == 0, ab, DEPTH);
    check({tag, " R6 valid window (act=first bad cycle)"}, bad_vld == 0, av, 2);
    check({tag, " R5 element order"}, bad_dat == 0, ad, ed);
    check({tag, " R7 lane copies"}, bad_lane == 0, al, ed);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  task automatic t_reset();
    do_reset();
  endtask

  task automatic t_fill_ramp();
    for (int w = 0; w < WORDS; w++) put_word(7);
    read_pass("R2 packing", 1'b0);
  endtask

  task automatic t_gaps();
    for (int w = 0; w < WORDS; w++) begin
      put_word(32'h3000_0001);
      if (w % 5 == 0) idle_garbage(2);
    end
    read_pass("R9 gaps", 1'b0);
  endtask

  task automatic t_wrap();
    for (int w = 0; w < 3; w++) put_word(32'h0123_4567);
    read_pass("R3 wrap", 1'b0);
  endtask

  task automatic t_restart_ignored();
    read_pass("R8 restart", 1'b1);
  endtask

  initial begin
    t_reset();
    t_fill_ramp();
    t_gaps();
    t_wrap();
    t_restart_ignored();
    finish_run();
  end
endmodule